// File: doc/BRIEF.md
# DDR Memory Power-Up Command Sequencer

This block walks a DDR memory device through its power-up command sequence once the chip leaves reset. A single start pulse launches the run. A mode input picks between the longer DDR2 sequence and the shorter DDR1 sequence. For every step the block first loads the mode or extended-mode value into its value register. It then raises exactly one bit of a command strobe bus and holds it until the memory command path acknowledges it. After each acknowledge it waits a fixed minimum gap before it moves on to the next step.

When the last mode write has been acknowledged and its gap has elapsed, the block raises `init_done_o` and presents the refresh control word. Bit 14 of that word is the enable and bits 13:0 are the interval in cycles. From then on a timer pulses a refresh request each time the interval expires, as long as the enable bit is set. Physical-layer timing, strobe tap tuning and read capture are handled elsewhere.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset the block is idle: `cmd_o` is 0, `busy_o`, `init_done_o` and `refresh_req_o` are low, and `refresh_word_o` is 0.
- R2: A start with `ddr2_sel_i`=1 issues eleven commands in this order, with these values on `mode_val_o` for the mode writes: precharge-all, EMR2 write 0x000, EMR3 write 0x000, EMR write 0x000 (DLL on), MR write 0x100 (DLL reset), precharge-all, refresh, refresh, MR write 0xA33 (write recovery 6, CAS latency 3, burst 8), EMR write 0x382 (OCD default, reduced drive, DLL on), EMR write 0x402 (OCD exit, reduced drive, DLL on).
- R3: A start with `ddr2_sel_i`=0 issues five commands: precharge-all, MR write 0x133, EMR write 0x002, precharge-all, MR write 0x033.
- R4: `cmd_o` is one-hot or zero. Bit 0 is MR write, bit 1 EMR write, bit 2 auto-refresh, bit 3 precharge-all, bit 4 EMR2 write and bit 5 EMR3 write. A strobe stays unchanged until the cycle after `cmd_ack_i` is seen high with it.
- R5: Each step spends one cycle with no strobe while its value is loaded. During a mode-write strobe, `mode_val_o` already holds that step's value and stays stable.
- R6: After an acknowledge, `cmd_o` stays 0 for MIN_GAP cycles before the next step's load cycle.
- R7: A start while busy, or after `init_done_o`, has no effect on the commands, the selected sequence or the status outputs.
- R8: `init_done_o` rises MIN_GAP cycles after the last acknowledge and stays high until reset. From then on `refresh_word_o` equals REFRESH_WORD (default 0x4186: enable bit 14 set, interval 0x186).
- R9: While done and the enable bit is set, `refresh_req_o` pulses for one cycle on the k-th done cycle whenever k is a multiple of the interval. With the enable bit clear it never pulses.
- R10: `cmd_ack_i` is ignored whenever no strobe is asserted, including when it is held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| ddr2_sel_i | input | 1 | 1 selects the DDR2 sequence, 0 the DDR1 sequence, sampled with start |
| cmd_ack_i | input | 1 | Acknowledge from the memory command path |
| cmd_o | output | 6 | One-hot command strobe |
| mode_val_o | output | 16 | Value for the current mode-register write |
| busy_o | output | 1 | Sequence in progress |
| init_done_o | output | 1 | Sequence complete |
| refresh_word_o | output | 16 | Refresh control word, enable bit 14, interval 13:0 |
| refresh_req_o | output | 1 | Periodic auto-refresh request pulse |

## Verification
Both sequences are run with three acknowledge patterns. An immediate acknowledge shows that the minimum gap, and not the acknowledge, sets the pace. A late acknowledge shows that strobes and values are held. An acknowledge tied high shows that it is ignored outside a strobe. The DDR2 run gets start pulses with the other mode selected mid-sequence, and a start after completion, which exposes a block that restarts or switches sequences. A second instance with the enable bit cleared receives identical stimulus, which separates gating by the enable bit from gating by completion. The DDR2 run continues for two refresh intervals so that the timer's period and its first pulse are both checked.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;
  localparam int CMD_W      = 6;
  localparam int VAL_W      = 16;
  localparam int DDR2_STEPS = 11;
  localparam int DDR1_STEPS = 5;
  localparam int MAX_STEPS  = (DDR2_STEPS > DDR1_STEPS) ? DDR2_STEPS : DDR1_STEPS;
  localparam int IDX_W      = $clog2(MAX_STEPS);

  typedef logic [CMD_W-1:0] cmd_t;

  // strobe bit positions are decoded by the memory command path
  localparam cmd_t C_MR   = 6'b000001;
  localparam cmd_t C_EMR  = 6'b000010;
  localparam cmd_t C_REF  = 6'b000100;
  localparam cmd_t C_PALL = 6'b001000;
  localparam cmd_t C_EMR2 = 6'b010000;
  localparam cmd_t C_EMR3 = 6'b100000;
  localparam cmd_t C_LOADS = C_MR | C_EMR | C_EMR2 | C_EMR3;

  typedef struct packed {
    cmd_t             cmd;
    logic [VAL_W-1:0] val;
  } step_t;

  typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_ISSUE, PH_GAP, PH_DONE} phase_t;

  function automatic step_t mk(input cmd_t c, input logic [VAL_W-1:0] v);
    step_t s;
    s.cmd = c;
    s.val = v;
    return s;
  endfunction

  function automatic step_t ddr2_step(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return mk(C_PALL, 16'h0000);
      4'd1:    return mk(C_EMR2, 16'h0000);
      4'd2:    return mk(C_EMR3, 16'h0000);
      4'd3:    return mk(C_EMR,  16'h0000);
      4'd4:    return mk(C_MR,   16'h0100);
      4'd5:    return mk(C_PALL, 16'h0000);
      4'd6:    return mk(C_REF,  16'h0000);
      4'd7:    return mk(C_REF,  16'h0000);
      4'd8:    return mk(C_MR,   16'h0A33);
      4'd9:    return mk(C_EMR,  16'h0382);
      default: return mk(C_EMR,  16'h0402);
    endcase
  endfunction

  function automatic step_t ddr1_step(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return mk(C_PALL, 16'h0000);
      4'd1:    return mk(C_MR,   16'h0133);
      4'd2:    return mk(C_EMR,  16'h0002);
      4'd3:    return mk(C_PALL, 16'h0000);
      default: return mk(C_MR,   16'h0033);
    endcase
  endfunction

  function automatic logic is_load(input cmd_t c);
    return |(c & C_LOADS);
  endfunction
endpackage

// File: rtl/ddr_init_steps.sv
`timescale 1ns/1ps
module ddr_init_steps
  import ddr_init_pkg::*;
(
  input  logic             ddr2_i,
  input  logic [IDX_W-1:0] idx_i,
  output cmd_t             cmd_o,
  output logic [VAL_W-1:0] val_o,
  output logic             is_load_o,
  output logic             last_o
);
  step_t s;

  always_comb begin
    s         = ddr2_i ? ddr2_step(idx_i) : ddr1_step(idx_i);
    cmd_o     = s.cmd;
    val_o     = s.val;
    is_load_o = is_load(s.cmd);
    last_o    = ddr2_i ? (idx_i == IDX_W'(DDR2_STEPS - 1))
                       : (idx_i == IDX_W'(DDR1_STEPS - 1));
  end
endmodule

// File: rtl/ddr_init_pacer.sv
`timescale 1ns/1ps
module ddr_init_pacer
  import ddr_init_pkg::*;
#(
  parameter int MIN_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  input  logic last_i,
  output logic launch_o,
  output logic load_o,
  output logic issue_o,
  output logic step_adv_o,
  output logic busy_o,
  output logic done_o
);
  localparam int GW = (MIN_GAP < 2) ? 1 : $clog2(MIN_GAP);

  phase_t        ph;
  logic [GW-1:0] gap_cnt;
  logic          gap_end;

  assign gap_end    = (ph == PH_GAP) && (gap_cnt == GW'(MIN_GAP - 1));
  assign launch_o   = (ph == PH_IDLE) && start_i;
  assign load_o     = (ph == PH_LOAD);
  assign issue_o    = (ph == PH_ISSUE);
  assign step_adv_o = gap_end && !last_i;
  assign busy_o     = (ph == PH_LOAD) || (ph == PH_ISSUE) || (ph == PH_GAP);
  assign done_o     = (ph == PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      gap_cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE:  if (start_i) ph <= PH_LOAD;
        PH_LOAD:  ph <= PH_ISSUE;
        PH_ISSUE: if (ack_i) begin
                    ph      <= PH_GAP;
                    gap_cnt <= '0;
                  end
        PH_GAP:   if (gap_end) ph <= last_i ? PH_DONE : PH_LOAD;
                  else         gap_cnt <= gap_cnt + 1'b1;
        PH_DONE:  ph <= PH_DONE;
        default:  ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_refresh_timer.sv
`timescale 1ns/1ps
module ddr_refresh_timer #(
  parameter int IVL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             en_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             req_o
);
  logic [IVL_W-1:0] cnt;

  assign req_o = run_i && en_i && (ivl_i != '0) && (cnt == ivl_i - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) cnt <= '0;
    else if (req_o)       cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int          MIN_GAP      = 3,
  parameter logic [15:0] REFRESH_WORD = 16'h4186
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ddr2_sel_i,
  input  logic             cmd_ack_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [VAL_W-1:0] mode_val_o,
  output logic             busy_o,
  output logic             init_done_o,
  output logic [15:0]      refresh_word_o,
  output logic             refresh_req_o
);
  localparam int REF_EN_BIT = 14;
  localparam int IVL_W      = 14;

  // named internal events, brought out for the checker
  logic             launch, load_phase, issue_phase, step_adv, done;
  logic             ddr2_q;
  logic [IDX_W-1:0] idx;
  cmd_t             step_cmd;
  logic [VAL_W-1:0] step_val, val_q;
  logic             step_is_load, step_last;

  ddr_init_pacer #(.MIN_GAP(MIN_GAP)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ack_i      (cmd_ack_i),
    .last_i     (step_last),
    .launch_o   (launch),
    .load_o     (load_phase),
    .issue_o    (issue_phase),
    .step_adv_o (step_adv),
    .busy_o     (busy_o),
    .done_o     (done)
  );

  ddr_init_steps u_steps (
    .ddr2_i    (ddr2_q),
    .idx_i     (idx),
    .cmd_o     (step_cmd),
    .val_o     (step_val),
    .is_load_o (step_is_load),
    .last_o    (step_last)
  );

  ddr_refresh_timer #(.IVL_W(IVL_W)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (done),
    .en_i  (REFRESH_WORD[REF_EN_BIT]),
    .ivl_i (REFRESH_WORD[IVL_W-1:0]),
    .req_o (refresh_req_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      ddr2_q <= 1'b0;
      val_q  <= '0;
    end else begin
      if (launch) begin
        idx    <= '0;
        ddr2_q <= ddr2_sel_i;
      end else if (step_adv) begin
        idx <= idx + 1'b1;
      end
      if (load_phase && step_is_load) val_q <= step_val;
    end
  end

  assign cmd_o          = issue_phase ? step_cmd : '0;
  assign mode_val_o     = val_q;
  assign init_done_o    = done;
  assign refresh_word_o = done ? REFRESH_WORD : 16'h0000;
endmodule

// File: rtl/ddr_init_seq_chk.sv
`timescale 1ns/1ps
module ddr_init_seq_chk #(
  parameter int          MIN_GAP      = 3,
  parameter logic [15:0] REFRESH_WORD = 16'h4186
) (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  cmd_o,
  input logic        cmd_ack_i,
  input logic [15:0] mode_val_o,
  input logic        init_done_o,
  input logic        refresh_req_o,
  input logic        load_phase,
  input logic        step_adv
);
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_o));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 6'd0) && !cmd_ack_i) |=> $stable(cmd_o));

  p_val_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 6'd0) && !cmd_ack_i) |=> $stable(mode_val_o));

  p_load_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_phase |=> (cmd_o != 6'd0));

  p_drop_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != 6'd0) && cmd_ack_i) |=> (cmd_o == 6'd0));

  p_adv_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |-> (cmd_o == 6'd0));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |-> (cmd_o == 6'd0));

  p_ref_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req_o |-> (init_done_o && REFRESH_WORD[14]));

  p_ref_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req_o && (REFRESH_WORD[13:0] > 14'd1)) |=> !refresh_req_o);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .MIN_GAP      (MIN_GAP),
  .REFRESH_WORD (REFRESH_WORD)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_o         (cmd_o),
  .cmd_ack_i     (cmd_ack_i),
  .mode_val_o    (mode_val_o),
  .init_done_o   (init_done_o),
  .refresh_req_o (refresh_req_o),
  .load_phase    (load_phase),
  .step_adv      (step_adv)
);

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;
  localparam int GAP = 3;
  localparam int IVL = 'h186;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, ddr2_sel, ack;
  logic [5:0]  cmd, cmd_off;
  logic [15:0] val, val_off, rword, rword_off;
  logic        busy, busy_off, done, done_off, rreq, rreq_off;

  ddr_init_seq #(.MIN_GAP(GAP), .REFRESH_WORD(16'h4186)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ddr2_sel_i(ddr2_sel),
    .cmd_ack_i(ack), .cmd_o(cmd), .mode_val_o(val), .busy_o(busy),
    .init_done_o(done), .refresh_word_o(rword), .refresh_req_o(rreq));

  ddr_init_seq #(.MIN_GAP(GAP), .REFRESH_WORD(16'h0186)) u_dut_off (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ddr2_sel_i(ddr2_sel),
    .cmd_ack_i(ack), .cmd_o(cmd_off), .mode_val_o(val_off), .busy_o(busy_off),
    .init_done_o(done_off), .refresh_word_o(rword_off), .refresh_req_o(rreq_off));

  // expected sequences written from the requirements
  int e2_cmd [11] = '{8, 16, 32, 2, 1, 8, 4, 4, 1, 2, 2};
  int e2_val [11] = '{0, 0, 0, 0, 'h100, 0, 0, 0, 'hA33, 'h382, 'h402};
  int e1_cmd [5]  = '{8, 1, 2, 8, 1};
  int e1_val [5]  = '{0, 'h133, 'h002, 0, 'h033};

  int checks = 0, errors = 0, cyc = 0;
  // reference model: 0 idle, 1 load, 2 strobe, 3 gap, 4 done
  int m_ph = 0, m_idx = 0, m_g = 0, m_ddr2 = 0, m_val = 0, t_done = 0;
  int ack_lat = 0, ack_wait = 0, n_cmds = 0, prev_cmd = 0;
  bit ack_stuck = 0;

  function automatic int m_len();
    return m_ddr2 ? 11 : 5;
  endfunction
  function automatic int m_cmd_at(int i);
    return m_ddr2 ? e2_cmd[i] : e1_cmd[i];
  endfunction
  function automatic int m_val_at(int i);
    return m_ddr2 ? e2_val[i] : e1_val[i];
  endfunction
  function automatic bit writes_mode(int c);
    return (c == 1) || (c == 2) || (c == 16) || (c == 32);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic compare();
    int ec;
    bit ereq;
    ec   = (m_ph == 2) ? m_cmd_at(m_idx) : 0;
    ereq = (m_ph == 4) && (((cyc - t_done + 1) % IVL) == 0);
    chk(m_ddr2 ? "R2 strobe" : "R3 strobe", int'(cmd), ec);
    chk("R7 busy", int'(busy), (m_ph >= 1 && m_ph <= 3) ? 1 : 0);
    chk("R8 done", int'(done), (m_ph == 4) ? 1 : 0);
    chk("R8 refresh word", int'(rword), (m_ph == 4) ? 'h4186 : 0);
    if (m_ph == 2 && writes_mode(ec)) chk("R5 value", int'(val), m_val);
    chk("R9 refresh request", int'(rreq), int'(ereq));
    chk("R9 disabled request", int'(rreq_off), 0);
    chk("R9 disabled done", int'(done_off), (m_ph == 4) ? 1 : 0);
    if (cmd != 6'd0 && prev_cmd == 0) n_cmds++;
    prev_cmd = int'(cmd);
  endtask

  task automatic model_edge();
    cyc++;
    case (m_ph)
      0: if (start) begin m_ph = 1; m_idx = 0; m_ddr2 = int'(ddr2_sel); end
      1: begin
           m_ph = 2;
           if (writes_mode(m_cmd_at(m_idx))) m_val = m_val_at(m_idx);
         end
      2: if (ack) begin m_ph = 3; m_g = 0; end
      3: if (m_g == GAP - 1) begin
           if (m_idx == m_len() - 1) begin m_ph = 4; t_done = cyc; end
           else begin m_idx++; m_ph = 1; end
         end else m_g++;
      default: ;
    endcase
  endtask

  // call at a falling edge: compare, drive acknowledge, take one rising edge
  task automatic step_cycle();
    compare();
    if (ack_stuck) ack = 1'b1;
    else if (cmd != 6'd0) begin
      ack = (ack_wait >= ack_lat);
      ack_wait++;
    end else begin
      ack = 1'b0;
      ack_wait = 0;
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; ack = 1'b0; ddr2_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_ph = 0; m_idx = 0; m_g = 0; m_val = 0; prev_cmd = 0; ack_wait = 0;
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 refresh request", int'(rreq), 0);
    chk("R1 refresh word", int'(rword), 0);
  endtask

  task automatic run_seq(bit d2, int lat, bit stuck, bit mid_start, int extra);
    ddr2_sel = d2; ack_lat = lat; ack_stuck = stuck; n_cmds = 0;
    start = 1'b1;
    step_cycle();
    start = 1'b0;
    for (int i = 0; i < 500 && m_ph != 4; i++) begin
      if (mid_start && (i == 6 || i == 20)) begin start = 1'b1; ddr2_sel = !d2; end
      else start = 1'b0;
      step_cycle();
    end
    start = 1'b0;
    chk(d2 ? "R2 command count" : "R3 command count", n_cmds, d2 ? 11 : 5);
    chk(d2 ? "R2 completion" : "R3 completion", int'(done), 1);
    for (int i = 0; i < extra; i++) step_cycle();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // DDR2, immediate ack, mid-run starts with DDR1 selected (R2 R6 R7 R9)
    run_seq(1'b1, 0, 1'b0, 1'b1, 2 * IVL + 20);
    // start after completion is ignored (R7)
    n_cmds = 0;
    start = 1'b1; ddr2_sel = 1'b0;
    step_cycle();
    start = 1'b0;
    for (int i = 0; i < 12; i++) step_cycle();
    chk("R7 start after done", n_cmds, 0);
    // DDR1, late ack: strobe and value held (R3 R4 R5)
    do_reset();
    run_seq(1'b0, 3, 1'b0, 1'b0, 10);
    // DDR2, ack tied high: ignored outside strobes (R10)
    do_reset();
    run_seq(1'b1, 0, 1'b1, 1'b0, 10);
    chk("R10 stuck ack sequence length", n_cmds, 11);
    // DDR1, ack tied high (R10 R3)
    do_reset();
    run_seq(1'b0, 0, 1'b1, 1'b0, 5);
    chk("R10 stuck ack done", int'(done), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule